// File: doc/BRIEF.md
# Reloading Down-Count Timer

This block is a programmable down-counter with two storage registers: a reload latch and the live count register. Each enabled count pulse lowers the count by one. A pulse that arrives while the count is zero is an underflow. On an underflow the count is reloaded from the latch, counting carries on by itself, and a sticky interrupt request flag is set. The period is therefore the latch value plus one count pulses.

The count pulse comes from one of two sources. The internal source is the core clock divided by a fixed prescale factor of 16. The external source is an edge on an asynchronous input pin; that input is synchronised first, and a control bit selects whether the rising or the falling edge counts. An 8-bit register port gives access to the timer through three addresses:
- Count low byte.
- Count high byte.
- Control byte, which holds the stop bit, the write-mode bit, the source select, the edge select and the interrupt flag.

One parameter builds the counter as either 8 or 16 bits wide.

Top module: `dcount_timer`

## Requirements
- R1: After synchronous reset the count and the latch both hold all ones, and the stop bit is set. The interrupt flag is clear, so the control byte at address 2 reads 0x01.
- R2: While counting is enabled, each count pulse lowers the count by exactly one.
- R3: A count pulse that arrives while the count is zero is an underflow: the count is loaded from the latch. From one reload to the next there are latch+1 count pulses.
- R4: Every underflow sets the interrupt flag, which is driven on `irqReq` and also read as control bit 4. The flag stays set until a control write with bit 4 = 1 clears it.
- R5: With control bit 2 = 0, one count pulse occurs every 16 clock cycles from a free-running prescaler. Any 128 consecutive running cycles therefore remove exactly 8 from the count.
- R6: With control bit 2 = 1, the count pulses come from `extIn`. Bit 3 = 0 counts rising edges only and bit 3 = 1 counts falling edges only. Each active edge gives exactly one pulse.
- R7: While control bit 0 (stop) is 1, count pulses are ignored and the count keeps its value.
- R8: A data write to address 0 or 1 sets that byte of the latch. When control bit 1 = 0 the same byte of the count is written too. When bit 1 = 1 the count is untouched, and the new latch value takes effect at the next reload.
- R9: Reading address 0 returns the count low byte and, at the clock edge, copies the count high byte into a holding register. Reading address 1 returns that holding register, so the two bytes form one coherent 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (captures the high byte when reading address 0) |
| busAddr | input | 2 | Register address: 0 count low, 1 count high, 2 control |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the current address (combinational) |
| extIn | input | 1 | Asynchronous external count input |
| irqReq | output | 1 | Sticky interrupt request flag |

## Verification
The hardest condition to reach is an underflow whose exact position in the sequence of pulses is known. The prescaler phase cannot be seen at the ports. The bench therefore drives the exact underflow and reload tests from the external input, one edge at a time, and leaves enough settling cycles after each edge for the synchronizer. The internal divider is measured by a different route: the bench opens a run window of exactly 128 cycles between two control writes. Any such window contains exactly eight prescaler pulses, whatever the prescaler phase. A write in latch-only mode is checked across a reload, so that the stale count visibly runs out before the new latch value appears.

// File: rtl/dcount_timer_pkg.sv
package dcount_timer_pkg;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  // control byte bit positions
  localparam int CB_STOP   = 0;
  localparam int CB_LONLY  = 1;
  localparam int CB_EXTSRC = 2;
  localparam int CB_FALL   = 3;
  localparam int CB_IRQ    = 4;

  typedef struct packed {
    logic             wrLatchLo;
    logic             wrLatchHi;
    logic             wrCntLo;
    logic             wrCntHi;
    logic             capHi;
    logic             irqClr;
    logic             countEn;
    logic [BUS_W-1:0] wdata;
  } tmr_strobe_t;

endpackage

// File: rtl/dcount_timer_ctrl.sv
module dcount_timer_ctrl
  import dcount_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              extIn,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [BUS_W-1:0]  holdHi,
  input  logic              irqFlag,
  output tmr_strobe_t       strobe
);

  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] psCnt;
  logic            tick;
  logic            syncA, syncB, syncPrev;
  logic            extEdge;
  logic            stopOn, latchOnly, srcExt, edgeFall;
  logic            wrCtrl;

  // free-running prescaler
  always_ff @(posedge clk) begin
    if (rst) psCnt <= '0;
    else if (psCnt == PS_LAST) psCnt <= '0;
    else psCnt <= psCnt + 1'b1;
  end
  assign tick = (psCnt == PS_LAST);

  // two-flop synchronizer plus edge history
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= extIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end
  assign extEdge = edgeFall ? (syncPrev & ~syncB) : (syncB & ~syncPrev);

  // control register
  assign wrCtrl = busWr && (busAddr == ADDR_CTRL);
  always_ff @(posedge clk) begin
    if (rst) begin
      stopOn    <= 1'b1;
      latchOnly <= 1'b0;
      srcExt    <= 1'b0;
      edgeFall  <= 1'b0;
    end else if (wrCtrl) begin
      stopOn    <= busWdata[CB_STOP];
      latchOnly <= busWdata[CB_LONLY];
      srcExt    <= busWdata[CB_EXTSRC];
      edgeFall  <= busWdata[CB_FALL];
    end
  end

  // strobes toward the datapath
  always_comb begin
    strobe           = '0;
    strobe.wdata     = busWdata;
    strobe.wrLatchLo = busWr && (busAddr == ADDR_CNT_LO);
    strobe.wrLatchHi = busWr && (busAddr == ADDR_CNT_HI) && (CNT_W > 8);
    strobe.wrCntLo   = strobe.wrLatchLo && !latchOnly;
    strobe.wrCntHi   = strobe.wrLatchHi && !latchOnly;
    strobe.capHi     = busRd && (busAddr == ADDR_CNT_LO);
    strobe.irqClr    = wrCtrl && busWdata[CB_IRQ];
    strobe.countEn   = !stopOn && (srcExt ? extEdge : tick);
  end

  // read mux
  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CNT_LO: busRdata = cntVal[BUS_W-1:0];
      ADDR_CNT_HI: busRdata = holdHi;
      ADDR_CTRL: begin
        busRdata[CB_STOP]   = stopOn;
        busRdata[CB_LONLY]  = latchOnly;
        busRdata[CB_EXTSRC] = srcExt;
        busRdata[CB_FALL]   = edgeFall;
        busRdata[CB_IRQ]    = irqFlag;
      end
      default: busRdata = '0;
    endcase
  end

  // R5: internal pulses are isolated single cycles
  a_r5_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R6: a detected external edge yields a single count pulse
  a_r6_one_per_edge: assert property (@(posedge clk) disable iff (rst)
    (srcExt && strobe.countEn && !busWr) |=> !strobe.countEn);

endmodule

// File: rtl/dcount_timer_dp.sv
module dcount_timer_dp
  import dcount_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_strobe_t      strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic [BUS_W-1:0] holdHi,
  output logic             irqFlag
);

  localparam bit HAS_HI = (CNT_W > BUS_W);

  logic [CNT_W-1:0] latchQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] latchNext;
  logic             underflow;

  assign underflow = strobe.countEn && (cntQ == '0);

  always_comb begin
    latchNext = latchQ;
    if (strobe.wrLatchLo) latchNext[BUS_W-1:0] = strobe.wdata;
    if (HAS_HI && strobe.wrLatchHi) latchNext[CNT_W-1 -: BUS_W] = strobe.wdata;
  end

  always_comb begin
    cntNext = cntQ;
    if (strobe.countEn) cntNext = underflow ? latchQ : cntQ - 1'b1;
    if (strobe.wrCntLo) cntNext[BUS_W-1:0] = strobe.wdata;
    if (HAS_HI && strobe.wrCntHi) cntNext[CNT_W-1 -: BUS_W] = strobe.wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latchQ  <= '1;
      cntQ    <= '1;
      irqFlag <= 1'b0;
      holdHi  <= HAS_HI ? '0 : '0;
    end else begin
      latchQ <= latchNext;
      cntQ   <= cntNext;
      if (underflow) irqFlag <= 1'b1;
      else if (strobe.irqClr) irqFlag <= 1'b0;
      if (strobe.capHi) holdHi <= HAS_HI ? cntQ[CNT_W-1 -: BUS_W] : '0;
    end
  end

  assign cntVal = cntQ;

  logic noCntWr;
  assign noCntWr = !strobe.wrCntLo && !strobe.wrCntHi;

  // R2: nonzero count steps down by one per pulse
  a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
    (strobe.countEn && noCntWr && cntQ != '0) |=> cntQ == CNT_W'($past(cntQ) - 1'b1));

  // R3: pulse at zero reloads from latch
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    (strobe.countEn && noCntWr && cntQ == '0) |=> cntQ == $past(latchQ));

  // R4: underflow sets the flag
  a_r4_irq_set: assert property (@(posedge clk) disable iff (rst)
    underflow |=> irqFlag);

  // R4: flag is sticky until cleared
  a_r4_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irqFlag && !strobe.irqClr) |=> irqFlag);

  // R8: latch-only write leaves the count alone
  a_r8_latch_only: assert property (@(posedge clk) disable iff (rst)
    ((strobe.wrLatchLo || strobe.wrLatchHi) && noCntWr && !strobe.countEn) |=> $stable(cntQ));

  // R9: holding register changes only on a low-byte read
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !strobe.capHi |=> $stable(holdHi));

endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import dcount_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       extIn,
  output logic       irqReq
);

  tmr_strobe_t      strobe;
  logic [CNT_W-1:0] cntVal;
  logic [BUS_W-1:0] holdHi;
  logic             irqFlag;

  dcount_timer_ctrl #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) ctrl_i (
    .clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extIn(extIn),
    .cntVal(cntVal), .holdHi(holdHi), .irqFlag(irqFlag), .strobe(strobe)
  );

  dcount_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .cntVal(cntVal), .holdHi(holdHi), .irqFlag(irqFlag)
  );

  assign irqReq = irqFlag;

endmodule

// File: tb/dcount_timer_tb_top.sv
module dcount_timer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       extIn = 1'b0;
  logic       irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcount_timer dut_i (
    .clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extIn(extIn), .irqReq(irqReq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input int exp);
    busRd = 1'b1; busAddr = a;
    #1 chk(tag, busRdata, exp);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic ext(input logic v);
    extIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset();
    rd(2'd0, "R1 count low", 8'hFF);
    rd(2'd1, "R1 count high", 8'hFF);
    rd(2'd2, "R1 control", 8'h01);
    chk("R1 irqReq", irqReq, 0);
  endtask

  task automatic test_ext_rising();
    wr(2'd2, 8'h04);              // run, ext, rising, write both
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h00);
    rd(2'd0, "R8 both-mode write", 8'h05);
    ext(1'b1);
    rd(2'd0, "R2 one rising edge", 8'h04);
    ext(1'b0);
    rd(2'd0, "R6 falling ignored", 8'h04);
    for (int i = 0; i < 4; i++) begin ext(1'b1); ext(1'b0); end
    rd(2'd0, "R2 count reaches zero", 8'h00);
    chk("R4 no irq before underflow", irqReq, 0);
    ext(1'b1);
    rd(2'd0, "R3 reload after zero", 8'h05);
    chk("R4 irq on underflow", irqReq, 1);
  endtask

  task automatic test_irq_clear();
    repeat (10) @(negedge clk);
    chk("R4 irq sticky", irqReq, 1);
    rd(2'd2, "R4 irq in control", 8'h14);
    wr(2'd2, 8'h14);
    chk("R4 irq cleared", irqReq, 0);
    rd(2'd2, "R4 control after clear", 8'h04);
  endtask

  task automatic test_falling_and_stop();
    wr(2'd2, 8'h0C);              // falling edge select; extIn is now 1
    ext(1'b0);
    rd(2'd0, "R6 falling counts", 8'h04);
    ext(1'b1);
    rd(2'd0, "R6 rising ignored", 8'h04);
    wr(2'd2, 8'h0D);              // stop
    for (int i = 0; i < 2; i++) begin ext(1'b0); ext(1'b1); end
    rd(2'd0, "R7 stopped holds", 8'h04);
    wr(2'd2, 8'h0C);
  endtask

  task automatic test_latch_only();
    wr(2'd2, 8'h0E);              // latch-only, falling, ext
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h00);
    rd(2'd0, "R8 latch-only keeps count", 8'h04);
    for (int i = 0; i < 4; i++) begin ext(1'b0); ext(1'b1); end
    rd(2'd0, "R8 old count runs out", 8'h00);
    ext(1'b0); ext(1'b1);
    rd(2'd0, "R8 new latch on reload", 8'h02);
    wr(2'd2, 8'h1E);
    for (int i = 0; i < 2; i++) begin ext(1'b0); ext(1'b1); end
    chk("R3 no underflow before latch+1", irqReq, 0);
    ext(1'b0); ext(1'b1);
    chk("R3 underflow at latch+1", irqReq, 1);
    rd(2'd0, "R3 reload again", 8'h02);
  endtask

  task automatic test_coherent();
    wr(2'd2, 8'h11);              // stop, write both, clear irq
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h12);
    rd(2'd0, "R9 low byte", 8'hFF);
    wr(2'd1, 8'h34);
    rd(2'd1, "R9 held high byte", 8'h12);
    rd(2'd0, "R9 low again", 8'hFF);
    rd(2'd1, "R9 fresh high byte", 8'h34);
  endtask

  task automatic test_prescale();
    wr(2'd2, 8'h01);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);              // run on internal source
    repeat (127) @(negedge clk);
    wr(2'd2, 8'h01);              // stop exactly 128 cycles later
    rd(2'd0, "R5 eight pulses in 128 cycles", 8'hF7);
    rd(2'd1, "R5 high byte", 8'h00);
    repeat (40) @(negedge clk);
    rd(2'd0, "R7 stopped internal", 8'hF7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_ext_rising();
    test_irq_clear();
    test_falling_and_stop();
    test_latch_only();
    test_coherent();
    test_prescale();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule